// File: doc/BRIEF.md
# Memory-Card Command Issue and Response Capture

This block sits behind the register interface of a memory-card host controller and handles everything that follows a write to the command register. It decodes the 16-bit command word and decides whether the word starts a real command or only a card-initialisation sequence. For a real command it raises a request toward the card side, carrying the command index and a 32-bit argument. It then waits until the card side hands back a response as a byte vector with a length.

When the response arrives, the block works out the expected response shape from the command word. It decides whether the response arrived complete or counts as a timeout, and checks the card status bits against an error mask chosen for that shape. It stores the response bytes in eight 16-bit response registers and sets the command-related status bits, which software clears by writing ones. A command that moves data also flushes the data FIFO and marks a transfer as active, with its direction. The FIFO itself and the data movement sit in a neighbouring block.

Top module: `cardCmdIssue`

## Requirements
- R1: A command write (regAddr 0) that is accepted and is not an init-only word raises cardReqValid on the next cycle. The request carries cardCmdIndex = command bits 5:0 and cardArg = the 32-bit argument. cardReqValid, together with cmdBusy, stays high until the cycle in which cardRspValid is seen.
- R2: A command write is ignored while ctrlEnable is low or while an earlier command is still waiting for its response. An ignored write changes no output.
- R3: Every accepted command word zeroes all eight response registers on the next cycle.
- R4: A command word with bit 7 (init) set and index 0 sends no request. It only sets status bit 0 on the next cycle, and it leaves the transfer flags unchanged.
- R5: Bits 10:8 select the response shape: 1 is a short status response, 2 is a long 16-byte response, 3 is an operating-conditions response and 6 is an address response. Every other code means no response. Code 1 with the busy bit 11 set is promoted to a busy variant that follows the same rules as code 1.
- R6: Shapes 1, 3 and 6 need at least 4 response bytes, and shape 2 needs 16. A shorter response sets status bit 7 (timeout) instead of bit 0 and leaves the response registers zero.
- R7: The status word of a response is {byte0, byte1, byte2, byte3}, with byte0 as the most significant byte. Status bit 14 is set when shape 1 gives a status with any bit of 0xFDF90000 set, or when shape 6 gives a low half with any of bits 15:13 set. In every other case a captured response clears bit 14.
- R8: For a complete shape-3 response whose status word has bit 31 clear, status bit 12 is set.
- R9: A complete response, or any no-response command, sets status bit 0. When the command index is 12 it also sets status bit 2.
- R10: After a complete response, register k (k = 0..7, at rspRegs bits 16k+15:16k) holds byte 2(7-k) in its upper half and byte 2(7-k)+1 in its lower half. Bytes at or beyond the shape's required length read as zero, so no-response commands leave all registers zero. Byte i of the card vector is cardRspBytes bits 8i+7:8i.
- R11: An accepted non-init command with bits 13:12 equal to 3 (data transfer) pulses fifoFlush for one cycle, sets xferActive and latches xferDir from bit 15 (1 = card to host). Any other command type clears xferActive.
- R12: A write to regAddr 1 replaces argument bits 15:0 only, and a write to regAddr 2 replaces bits 31:16 only.
- R13: With statusClrEn high, each one in statusClrMask clears that status bit, and a status bit set in the same cycle stays set. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlEnable | input | 1 | Controller enable; command writes only count while high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | 0 command, 1 argument low, 2 argument high, 3 unused |
| regWrData | input | 16 | Register write data |
| statusClrEn | input | 1 | Status clear strobe |
| statusClrMask | input | 16 | Write-one-to-clear mask for status |
| cardReqValid | output | 1 | Command request pending toward the card |
| cardCmdIndex | output | 6 | Index of the pending command |
| cardArg | output | 32 | Command argument |
| cardRspValid | input | 1 | Card response handshake |
| cardRspLen | input | 5 | Number of valid response bytes |
| cardRspBytes | input | 128 | Response bytes, byte i at bits 8i+7:8i |
| rspRegs | output | 128 | Eight response registers, word k at bits 16k+15:16k |
| status | output | 16 | Command status bits |
| cmdBusy | output | 1 | A command waits for its response |
| xferActive | output | 1 | A data-transfer command is active |
| xferDir | output | 1 | Latched transfer direction, 1 = card to host |
| fifoFlush | output | 1 | One-cycle request to empty the data FIFO |

## Verification
The hardest situations to reach are the ones where several rules meet in one response. Examples are a long response one byte short, a busy-promoted short response with error bits in its top byte, and a stop command with a short reply. The bench reaches them with a sweep over every response code and both busy values, five response lengths on each side of the limits, three byte patterns and rotating command types, with index 12 mixed in. It also catches a status clear and a status set arriving on the same edge, and a second command written while the first is still pending, by driving those inputs on the exact cycle of capture or waiting.

// File: rtl/cardCmdPkg.sv
package cardCmdPkg;

  localparam int REG_W = 16;
  localparam int IDX_W = 6;

  // command word fields
  localparam int F_INIT   = 7;
  localparam int F_BUSY   = 11;
  localparam int F_DIR    = 15;
  localparam int F_RTYPE  = 8;
  localparam int F_CTYPE  = 12;
  localparam logic [1:0] CTYPE_DATA = 2'd3;

  // status bit positions
  localparam int ST_END     = 0;
  localparam int ST_STOP    = 2;
  localparam int ST_TIMEOUT = 7;
  localparam int ST_OCRLOW  = 12;
  localparam int ST_RSPERR  = 14;

  typedef enum logic [2:0] {
    KIND_NONE, KIND_SHORT, KIND_SHORTBUSY, KIND_LONG, KIND_OCR, KIND_ADDR
  } rspKind_t;

  typedef struct packed {
    logic     clearRsp;
    logic     initDone;
    logic     capture;
    logic     startXfer;
    logic     endXfer;
    logic     dirToHost;
    logic     stopCmd;
    rspKind_t kind;
  } cmdStrobe_t;

  function automatic rspKind_t decodeKind(input logic [2:0] code, input logic busy);
    case (code)
      3'd1:    return busy ? KIND_SHORTBUSY : KIND_SHORT;
      3'd2:    return KIND_LONG;
      3'd3:    return KIND_OCR;
      3'd6:    return KIND_ADDR;
      default: return KIND_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cardCmdCtrl.sv
module cardCmdCtrl
  import cardCmdPkg::*;
#(
  parameter int STOP_INDEX = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlEnable,
  input  logic               cmdWr,
  input  logic [REG_W-1:0]   cmdWord,
  input  logic               cardRspValid,
  output cmdStrobe_t         strobe,
  output logic               cardReqValid,
  output logic [IDX_W-1:0]   cardCmdIndex,
  output logic               cmdBusy
);

  typedef enum logic {S_IDLE, S_WAIT} ctrlState_t;

  ctrlState_t       state;
  rspKind_t         kindQ;
  logic [IDX_W-1:0] idxQ;
  logic             accept;
  logic             initOnly;

  assign accept   = cmdWr && ctrlEnable && (state == S_IDLE);
  assign initOnly = cmdWord[F_INIT] && (cmdWord[IDX_W-1:0] == '0);

  always_comb begin
    strobe = '0;
    if (accept) begin
      strobe.clearRsp = 1'b1;
      if (initOnly) begin
        strobe.initDone = 1'b1;
      end else begin
        strobe.startXfer = (cmdWord[F_CTYPE +: 2] == CTYPE_DATA);
        strobe.endXfer   = (cmdWord[F_CTYPE +: 2] != CTYPE_DATA);
        strobe.dirToHost = cmdWord[F_DIR];
      end
    end
    if (state == S_WAIT && cardRspValid) begin
      strobe.capture = 1'b1;
      strobe.kind    = kindQ;
      strobe.stopCmd = (idxQ == IDX_W'(STOP_INDEX));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      kindQ <= KIND_NONE;
      idxQ  <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept && !initOnly) begin
          state <= S_WAIT;
          kindQ <= decodeKind(cmdWord[F_RTYPE +: 3], cmdWord[F_BUSY]);
          idxQ  <= cmdWord[IDX_W-1:0];
        end
        S_WAIT: if (cardRspValid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cardReqValid = (state == S_WAIT);
  assign cmdBusy      = (state == S_WAIT);
  assign cardCmdIndex = idxQ;

  // R1: request stays up until the card answers
  assert_hold_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    cardReqValid && !cardRspValid |=> cardReqValid && $stable(cardCmdIndex));

  // R2: no request appears without an enabled command write
  assert_ignore_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cardReqValid && !(cmdWr && ctrlEnable) |=> !cardReqValid);

  // R4: init-only word never reaches the card
  assert_init_no_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    accept && initOnly |=> !cardReqValid);

endmodule

// File: rtl/cardCmdData.sv
module cardCmdData
  import cardCmdPkg::*;
#(
  parameter int          RSP_BYTES   = 16,
  parameter int          SHORT_BYTES = 4,
  parameter logic [31:0] R1_ERR_MASK = 32'hFDF9_0000,
  parameter logic [15:0] R6_ERR_MASK = 16'hE000,
  localparam int         WORDS       = RSP_BYTES / 2,
  localparam int         LEN_W       = $clog2(RSP_BYTES + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  cmdStrobe_t                   strobe,
  input  logic                         argWrLo,
  input  logic                         argWrHi,
  input  logic [REG_W-1:0]             wrData,
  input  logic                         statusClrEn,
  input  logic [REG_W-1:0]             statusClrMask,
  input  logic [LEN_W-1:0]             cardRspLen,
  input  logic [RSP_BYTES*8-1:0]       cardRspBytes,
  output logic [2*REG_W-1:0]           cardArg,
  output logic [WORDS*REG_W-1:0]       rspRegs,
  output logic [REG_W-1:0]             status,
  output logic                         xferActive,
  output logic                         xferDir,
  output logic                         fifoFlush
);

  logic [2*REG_W-1:0]                argQ;
  logic [WORDS-1:0][REG_W-1:0]       rspQ;
  logic [WORDS-1:0][REG_W-1:0]       rspNew;
  logic [RSP_BYTES-1:0][7:0]         keptBytes;
  logic [REG_W-1:0]                  statusQ;
  logic [REG_W-1:0]                  statusNext;
  logic [31:0]                       rspWord;
  int                                needBytes;
  logic                              timedOut;
  logic                              errHit;
  logic                              activeQ;
  logic                              dirQ;
  logic                              flushQ;

  always_comb begin
    case (strobe.kind)
      KIND_SHORT, KIND_SHORTBUSY, KIND_OCR, KIND_ADDR: needBytes = SHORT_BYTES;
      KIND_LONG:                                       needBytes = RSP_BYTES;
      default:                                         needBytes = 0;
    endcase
  end

  assign timedOut = (needBytes != 0) && (int'(cardRspLen) < needBytes);
  assign rspWord  = {cardRspBytes[7:0], cardRspBytes[15:8],
                     cardRspBytes[23:16], cardRspBytes[31:24]};

  always_comb begin
    errHit = 1'b0;
    if (!timedOut) begin
      case (strobe.kind)
        KIND_SHORT, KIND_SHORTBUSY: errHit = |(rspWord & R1_ERR_MASK);
        KIND_ADDR:                  errHit = |(rspWord[15:0] & R6_ERR_MASK);
        default:                    errHit = 1'b0;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < RSP_BYTES; i++) begin
      keptBytes[i] = (i < needBytes && !timedOut) ? cardRspBytes[8*i +: 8] : 8'h00;
    end
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    localparam int HI = 2 * (WORDS - 1 - k);
    assign rspNew[k] = {keptBytes[HI], keptBytes[HI+1]};
  end

  always_comb begin
    statusNext = statusQ;
    if (statusClrEn) statusNext = statusNext & ~statusClrMask;
    if (strobe.initDone) statusNext[ST_END] = 1'b1;
    if (strobe.capture) begin
      if (timedOut) begin
        statusNext[ST_TIMEOUT] = 1'b1;
      end else begin
        statusNext[ST_END] = 1'b1;
        if (strobe.stopCmd) statusNext[ST_STOP] = 1'b1;
        if (strobe.kind == KIND_OCR && !rspWord[31]) statusNext[ST_OCRLOW] = 1'b1;
      end
      statusNext[ST_RSPERR] = errHit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      argQ    <= '0;
      rspQ    <= '0;
      statusQ <= '0;
      activeQ <= 1'b0;
      dirQ    <= 1'b0;
      flushQ  <= 1'b0;
    end else begin
      if (argWrLo) argQ[REG_W-1:0]       <= wrData;
      if (argWrHi) argQ[2*REG_W-1:REG_W] <= wrData;
      if (strobe.clearRsp)     rspQ <= '0;
      else if (strobe.capture) rspQ <= rspNew;
      statusQ <= statusNext;
      flushQ  <= strobe.startXfer;
      if (strobe.startXfer) begin
        activeQ <= 1'b1;
        dirQ    <= strobe.dirToHost;
      end else if (strobe.endXfer) begin
        activeQ <= 1'b0;
      end
    end
  end

  assign cardArg    = argQ;
  assign rspRegs    = rspQ;
  assign status     = statusQ;
  assign xferActive = activeQ;
  assign xferDir    = dirQ;
  assign fifoFlush  = flushQ;

  // R3: accepted command leaves the response registers empty
  assert_clear_rsp_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearRsp |=> rspRegs == '0);

  // R6: a long response that falls short is a timeout
  assert_short_long_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && strobe.kind == KIND_LONG && int'(cardRspLen) < RSP_BYTES
      |=> status[ST_TIMEOUT] && rspRegs == '0);

  // R9: complete stop command marks both end bits
  assert_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && strobe.stopCmd && !timedOut |=> status[ST_END] && status[ST_STOP]);

  // R10: no-response commands store nothing
  assert_none_empty_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && strobe.kind == KIND_NONE |=> rspRegs == '0);

  // R11: flush pulse accompanies an active transfer
  assert_flush_active_R11: assert property (@(posedge clk) disable iff (!rstN)
    fifoFlush |-> xferActive);

endmodule

// File: rtl/cardCmdIssue.sv
module cardCmdIssue
  import cardCmdPkg::*;
#(
  parameter int RSP_BYTES  = 16,
  parameter int STOP_INDEX = 12,
  localparam int LEN_W     = $clog2(RSP_BYTES + 1),
  localparam int WORDS     = RSP_BYTES / 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ctrlEnable,
  input  logic                   regWrEn,
  input  logic [1:0]             regAddr,
  input  logic [15:0]            regWrData,
  input  logic                   statusClrEn,
  input  logic [15:0]            statusClrMask,
  output logic                   cardReqValid,
  output logic [5:0]             cardCmdIndex,
  output logic [31:0]            cardArg,
  input  logic                   cardRspValid,
  input  logic [LEN_W-1:0]       cardRspLen,
  input  logic [RSP_BYTES*8-1:0] cardRspBytes,
  output logic [WORDS*16-1:0]    rspRegs,
  output logic [15:0]            status,
  output logic                   cmdBusy,
  output logic                   xferActive,
  output logic                   xferDir,
  output logic                   fifoFlush
);

  cmdStrobe_t strobe;
  logic       cmdWr;
  logic       argWrLo;
  logic       argWrHi;

  assign cmdWr   = regWrEn && (regAddr == 2'd0);
  assign argWrLo = regWrEn && (regAddr == 2'd1);
  assign argWrHi = regWrEn && (regAddr == 2'd2);

  cardCmdCtrl #(.STOP_INDEX(STOP_INDEX)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlEnable   (ctrlEnable),
    .cmdWr        (cmdWr),
    .cmdWord      (regWrData),
    .cardRspValid (cardRspValid),
    .strobe       (strobe),
    .cardReqValid (cardReqValid),
    .cardCmdIndex (cardCmdIndex),
    .cmdBusy      (cmdBusy)
  );

  cardCmdData #(.RSP_BYTES(RSP_BYTES)) i_data (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .argWrLo       (argWrLo),
    .argWrHi       (argWrHi),
    .wrData        (regWrData),
    .statusClrEn   (statusClrEn),
    .statusClrMask (statusClrMask),
    .cardRspLen    (cardRspLen),
    .cardRspBytes  (cardRspBytes),
    .cardArg       (cardArg),
    .rspRegs       (rspRegs),
    .status        (status),
    .xferActive    (xferActive),
    .xferDir       (xferDir),
    .fifoFlush     (fifoFlush)
  );

endmodule

// File: tb/test_cardCmdIssue.sv
module test_cardCmdIssue;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         ctrlEnable = 1'b0;
  logic         regWrEn = 1'b0;
  logic [1:0]   regAddr = '0;
  logic [15:0]  regWrData = '0;
  logic         statusClrEn = 1'b0;
  logic [15:0]  statusClrMask = '0;
  logic         cardReqValid;
  logic [5:0]   cardCmdIndex;
  logic [31:0]  cardArg;
  logic         cardRspValid = 1'b0;
  logic [4:0]   cardRspLen = '0;
  logic [127:0] cardRspBytes = '0;
  logic [127:0] rspRegs;
  logic [15:0]  status;
  logic         cmdBusy;
  logic         xferActive;
  logic         xferDir;
  logic         fifoFlush;

  int  nVec = 0;
  int  nBad = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  cardCmdIssue i_cardCmdIssue (.*);

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic clearAll();
    @(negedge clk);
    statusClrEn = 1'b1; statusClrMask = 16'hFFFF;
    @(negedge clk);
    statusClrEn = 1'b0;
  endtask

  // expected status and registers from the requirement text
  task automatic model(input logic [2:0] code, input logic [5:0] idx, input int len,
                       input logic [127:0] b, output logic [15:0] st, output logic [127:0] regs);
    int need;
    logic to, err;
    logic [31:0] w;
    need = (code == 3'd2) ? 16 : ((code == 3'd1 || code == 3'd3 || code == 3'd6) ? 4 : 0);
    to = (need != 0) && (len < need);
    w = {b[7:0], b[15:8], b[23:16], b[31:24]};
    err = 1'b0;
    if (!to && code == 3'd1) err = (w & 32'hFDF9_0000) != 0;
    if (!to && code == 3'd6) err = (w[15:0] & 16'hE000) != 0;
    st = '0;
    st[7]  = to;
    st[0]  = !to;
    st[2]  = !to && idx == 6'd12;
    st[12] = !to && code == 3'd3 && !w[31];
    st[14] = err;
    regs = '0;
    for (int k = 0; k < 8; k++) begin
      int hi;
      hi = 2 * (7 - k);
      if (!to && hi < need)     regs[16*k+8 +: 8] = b[8*hi +: 8];
      if (!to && hi + 1 < need) regs[16*k +: 8]   = b[8*(hi+1) +: 8];
    end
  endtask

  function automatic logic [127:0] pattern(input int p);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) begin
      case (p)
        0:       v[8*i +: 8] = (i < 2) ? 8'h00 : 8'(i);
        1:       v[8*i +: 8] = 8'((i * 37 + 128) & 255);
        default: v[8*i +: 8] = 8'hFF;
      endcase
    end
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0]  expSt;
    logic [127:0] expRegs;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 reset status", 128'(status), 128'h0);
    check("R13 reset regs", rspRegs, 128'h0);
    check("R13 reset outputs", 128'({cardReqValid, cmdBusy, xferActive, xferDir, fifoFlush}), 128'h0);
    rstN = 1'b1;

    // R12 argument halves
    wrReg(2'd1, 16'h1234);
    wrReg(2'd2, 16'hABCD);
    check("R12 arg both", 128'(cardArg), 128'(32'hABCD_1234));
    wrReg(2'd1, 16'h5555);
    check("R12 low only", 128'(cardArg), 128'(32'hABCD_5555));
    wrReg(2'd2, 16'h0F0F);
    check("R12 high only", 128'(cardArg), 128'(32'h0F0F_5555));

    // R2 disabled controller ignores command
    wrReg(2'd0, 16'h3105);
    check("R2 disabled no req", 128'({cardReqValid, cmdBusy, xferActive, fifoFlush}), 128'h0);
    check("R2 disabled status", 128'(status), 128'h0);
    ctrlEnable = 1'b1;

    // R4 init-only
    wrReg(2'd0, 16'h3080);
    check("R4 init no req", 128'({cardReqValid, cmdBusy}), 128'h0);
    check("R4 init status", 128'(status), 128'h1);
    check("R4 init xfer untouched", 128'({xferActive, fifoFlush}), 128'h0);
    clearAll();

    // main sweep R1 R3 R5 R6 R7 R8 R9 R10 R11
    for (int code = 0; code < 8; code++) begin
      for (int busy = 0; busy < 2; busy++) begin
        for (int ls = 0; ls < 5; ls++) begin
          for (int p = 0; p < 3; p++) begin
            int len;
            logic [1:0] ctype;
            logic dir;
            logic [5:0] idx;
            logic [15:0] word;
            len = (ls == 0) ? 0 : (ls == 1) ? 3 : (ls == 2) ? 4 : (ls == 3) ? 15 : 16;
            ctype = 2'((p + code + ls) % 4);
            dir = ls[0];
            idx = (ls == p) ? 6'd12 : 6'((code * 5 + ls + 1) % 64);
            word = {dir, 1'b0, ctype, 1'(busy), 3'(code), 1'b0, 1'b0, idx};
            clearAll();
            check("R13 cleared", 128'(status), 128'h0);
            @(negedge clk);
            regWrEn = 1'b1; regAddr = 2'd0; regWrData = word;
            @(negedge clk);
            regWrEn = 1'b0;
            check("R1 req valid", 128'({cardReqValid, cmdBusy}), 128'h3);
            check("R1 req index", 128'(cardCmdIndex), 128'(idx));
            check("R1 req arg", 128'(cardArg), 128'(32'h0F0F_5555));
            check("R3 regs zeroed", rspRegs, 128'h0);
            check("R11 flush", 128'(fifoFlush), 128'(ctype == 2'd3));
            check("R11 active", 128'(xferActive), 128'(ctype == 2'd3));
            if (ctype == 2'd3) check("R11 dir", 128'(xferDir), 128'(dir));
            // R2: a second command while pending is ignored
            if (p == 1) begin
              regWrEn = 1'b1; regAddr = 2'd0; regWrData = 16'h0021;
              @(negedge clk);
              regWrEn = 1'b0;
              check("R2 pending ignored", 128'({cardReqValid, cardCmdIndex}), 128'({1'b1, idx}));
            end
            cardRspValid = 1'b1; cardRspLen = 5'(len); cardRspBytes = pattern(p);
            @(negedge clk);
            cardRspValid = 1'b0;
            model(3'(code), idx, len, pattern(p), expSt, expRegs);
            check("R5 R6 R7 R8 R9 status", 128'(status), 128'(expSt));
            check("R10 regs", rspRegs, expRegs);
            check("R1 released", 128'({cardReqValid, cmdBusy, fifoFlush}), 128'h0);
          end
        end
      end
    end

    // R4: init-only leaves an active transfer untouched
    wrReg(2'd0, 16'h3002);
    cardRspValid = 1'b1; cardRspLen = 5'd0;
    @(negedge clk);
    cardRspValid = 1'b0;
    check("R11 adtc active", 128'(xferActive), 128'h1);
    wrReg(2'd0, 16'h0080);
    check("R4 init keeps xfer", 128'(xferActive), 128'h1);
    clearAll();

    // R13: set wins over clear on the same edge; partial clear
    wrReg(2'd0, 16'h010C);
    cardRspValid = 1'b1; cardRspLen = 5'd4; cardRspBytes = '0;
    statusClrEn = 1'b1; statusClrMask = 16'h0005;
    @(negedge clk);
    cardRspValid = 1'b0; statusClrEn = 1'b0;
    check("R13 set wins", 128'(status), 128'h5);
    check("R11 non-data clears active", 128'(xferActive), 128'h0);
    @(negedge clk);
    statusClrEn = 1'b1; statusClrMask = 16'h0004;
    @(negedge clk);
    statusClrEn = 1'b0;
    check("R13 partial clear", 128'(status), 128'h1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule